// File: doc/BRIEF.md
# Scanline Sprite Selector and Pixel Priority Resolver

The block prepares the sprite work for one display line. When `start` is pulsed it walks a 40-entry attribute table, one entry per clock, in ascending index order. Each entry is one 32-bit word: bits [7:0] hold the stored vertical position Y, bits [15:8] the stored horizontal position X, bits [23:16] the pattern number, and bits [31:24] flags that this block does not use. Every entry whose vertical extent covers the requested line is kept, up to a limit of ten. For each kept sprite the block stores its table index, its X and the byte address of the pattern row that the line needs.

After the walk the kept list can be read slot by slot. A combinational resolver then takes a screen column `pix_x` and reports which kept sprite owns that column. The sprite with the smaller X wins. When X is equal, the earlier table entry wins. Colour decoding and mixing with the background belong to later stages.

Top module: `spr_line_sel`

## Requirements
- R1: A scan starts on a `start` pulse while idle. `oam_idx` then presents entries 0,1,...,39 on consecutive cycles with `busy` high. `done` is high for exactly one cycle, 40 cycles after the edge that captured `start`, and `busy` falls at the same time.
- R2: With stored Y, line L and vertical offset YOFS (default 16), let d = L + YOFS − Y. An entry is selected only when 0 ≤ d < h, where h is 8 with `tall`=0 and 16 with `tall`=1.
- R3: At most 10 entries are kept. When more entries match, the first 10 in table order are kept and the rest are dropped. `slot_cnt` reports the number kept.
- R4: An entry whose stored X and Y are both 0 is never selected, whatever the line and offset.
- R5: The pattern row address is 0x8000 + 16·T + 2·r. Here r = d masked to 3 bits (`tall`=0) or 4 bits (`tall`=1). T is the pattern number, with bit 0 forced to 0 when `tall`=1.
- R6: Kept sprites occupy slots 0..`slot_cnt`−1 in table order. `rd_slot` selects a slot and returns its table index, X and row address. The list holds unchanged until the next scan starts.
- R7: A kept sprite covers column P when X − 8 ≤ P < X, with the comparison done as P + 8 − X in the range 0..7.
- R8: Among the kept sprites that cover `pix_x`, the winner has the smallest X. On equal X, the lower slot (earlier table index) wins. `win_slot` and `win_idx` identify the winner.
- R9: When no kept sprite covers `pix_x`, `win_valid` is 0 and `win_slot` and `win_idx` are 0.
- R10: After reset, `busy`, `done`, `slot_cnt` and `win_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan for `line_y` |
| line_y | input | 8 | Line number, captured at start |
| tall | input | 1 | Size mode: 0 = 8×8, 1 = 8×16, captured at start |
| oam_idx | output | 6 | Attribute table entry being read |
| oam_rdata | input | 32 | Entry word for `oam_idx`, same cycle |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle scan completion pulse |
| slot_cnt | output | 4 | Number of kept sprites |
| rd_slot | input | 4 | Slot selected for readout |
| rd_idx | output | 6 | Table index in selected slot |
| rd_x | output | 8 | Stored X in selected slot |
| rd_addr | output | 16 | Pattern row address in selected slot |
| pix_x | input | 8 | Screen column to resolve |
| win_valid | output | 1 | Some kept sprite covers `pix_x` |
| win_slot | output | 4 | Winning slot |
| win_idx | output | 6 | Table index of winning sprite |

## Verification
The hardest situation to reach from the ports is the overflow case with interleaved non-matches. More than ten entries match, non-matching entries sit between them, and the match that should be dropped has a smaller X than the kept ones. The stimulus fills the table with twelve matches scattered among misses and puts a low X on the eleventh match. The expected list shows it absent, and a pixel probe over its columns confirms it never wins. The hidden-entry rule also cannot appear at the default offset, so a second instance with zero offset exposes it.

// File: rtl/spr_pkg.sv
package spr_pkg;

  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_st_e;

  localparam int ENTRY_W = 32;

endpackage

// File: rtl/spr_match.sv
module spr_match #(
  parameter int YOFS     = 16,
  parameter int LINE_W   = 8,
  parameter int ADDR_W   = 16,
  parameter logic [15:0] PAT_BASE = 16'h8000
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic              tall_i,
  input  logic [7:0]        ypos_i,
  input  logic [7:0]        xpos_i,
  input  logic [7:0]        pat_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int DW = LINE_W + 2;

  logic [DW-1:0] sum;
  logic [DW-1:0] diff;
  logic [DW-1:0] height;
  logic [3:0]    row;
  logic [7:0]    tile;
  logic          hidden;

  always_comb begin
    sum    = DW'(line_i) + DW'(YOFS);
    diff   = sum - DW'(ypos_i);
    height = tall_i ? DW'(16) : DW'(8);
    hidden = (xpos_i == 8'd0) && (ypos_i == 8'd0);
    hit_o  = (sum >= DW'(ypos_i)) && (diff < height) && !hidden;
    row    = diff[3:0] & (tall_i ? 4'hF : 4'h7);
    tile   = tall_i ? {pat_i[7:1], 1'b0} : pat_i;
    addr_o = ADDR_W'(PAT_BASE) + ADDR_W'({tile, 4'b0000}) + ADDR_W'({row, 1'b0});
  end

endmodule

// File: rtl/spr_slots.sv
module spr_slots #(
  parameter int MAX_SEL = 10,
  parameter int IDX_W   = 6,
  parameter int SLOT_W  = 4,
  parameter int ADDR_W  = 16
) (
  input  logic                          clk,
  input  logic                          wr_en,
  input  logic [SLOT_W-1:0]             wr_slot,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [7:0]                    wr_x,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [SLOT_W-1:0]             rd_slot,
  output logic [IDX_W-1:0]              rd_idx,
  output logic [7:0]                    rd_x,
  output logic [ADDR_W-1:0]             rd_addr,
  output logic [MAX_SEL-1:0][7:0]       x_all,
  output logic [MAX_SEL-1:0][IDX_W-1:0] idx_all
);
  logic [MAX_SEL-1:0][ADDR_W-1:0] addr_q;

  for (genvar g = 0; g < MAX_SEL; g++) begin : g_slot
    logic sel_en;
    assign sel_en = wr_en && (wr_slot == SLOT_W'(g));
    always_ff @(posedge clk) begin
      if (sel_en) begin
        idx_all[g] <= wr_idx;
        x_all[g]   <= wr_x;
        addr_q[g]  <= wr_addr;
      end
    end
  end

  always_comb begin
    rd_idx  = '0;
    rd_x    = '0;
    rd_addr = '0;
    if (rd_slot < SLOT_W'(MAX_SEL)) begin
      rd_idx  = idx_all[rd_slot];
      rd_x    = x_all[rd_slot];
      rd_addr = addr_q[rd_slot];
    end
  end

endmodule

// File: rtl/spr_prio.sv
module spr_prio #(
  parameter int MAX_SEL = 10,
  parameter int IDX_W   = 6,
  parameter int SLOT_W  = 4,
  parameter int CNT_W   = 4,
  parameter int XOFS    = 8,
  parameter int SPR_W   = 8
) (
  input  logic [7:0]                    pix_i,
  input  logic [CNT_W-1:0]              cnt_i,
  input  logic [MAX_SEL-1:0][7:0]       x_all,
  input  logic [MAX_SEL-1:0][IDX_W-1:0] idx_all,
  output logic                          win_valid,
  output logic [SLOT_W-1:0]             win_slot,
  output logic [IDX_W-1:0]              win_idx
);
  logic [MAX_SEL-1:0] cov;
  logic [8:0]         shifted;

  assign shifted = {1'b0, pix_i} + 9'(XOFS);

  for (genvar g = 0; g < MAX_SEL; g++) begin : g_cov
    logic [8:0] rel;
    assign rel    = shifted - {1'b0, x_all[g]};
    assign cov[g] = (CNT_W'(g) < cnt_i) && (shifted >= {1'b0, x_all[g]}) && (rel < 9'(SPR_W));
  end

  logic [7:0] best_x;

  always_comb begin
    win_valid = 1'b0;
    win_slot  = '0;
    best_x    = '0;
    for (int i = 0; i < MAX_SEL; i++) begin
      if (cov[i] && (!win_valid || (x_all[i] < best_x))) begin
        win_valid = 1'b1;
        win_slot  = SLOT_W'(i);
        best_x    = x_all[i];
      end
    end
    win_idx = win_valid ? idx_all[win_slot] : '0;
  end

endmodule

// File: rtl/spr_line_sel.sv
module spr_line_sel #(
  parameter int N_ENT   = 40,
  parameter int MAX_SEL = 10,
  parameter int YOFS    = 16,
  parameter int XOFS    = 8,
  parameter int IDX_W   = $clog2(N_ENT),
  parameter int SLOT_W  = $clog2(MAX_SEL),
  parameter int CNT_W   = $clog2(MAX_SEL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        line_y,
  input  logic              tall,
  output logic [IDX_W-1:0]  oam_idx,
  input  logic [31:0]       oam_rdata,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  slot_cnt,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [7:0]        rd_x,
  output logic [15:0]       rd_addr,
  input  logic [7:0]        pix_x,
  output logic              win_valid,
  output logic [SLOT_W-1:0] win_slot,
  output logic [IDX_W-1:0]  win_idx
);
  import spr_pkg::*;

  localparam int LAST = N_ENT - 1;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok = rst_pipe[1];

  scan_st_e         st_q, st_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] sel_q, sel_d;
  logic [7:0]       line_q, line_d;
  logic             tall_q, tall_d;
  logic             done_q, done_d;

  logic             hit;
  logic [15:0]      row_addr;
  logic             wr_en;

  spr_match #(.YOFS(YOFS), .LINE_W(8), .ADDR_W(16)) u_match (
    .line_i (line_q),
    .tall_i (tall_q),
    .ypos_i (oam_rdata[7:0]),
    .xpos_i (oam_rdata[15:8]),
    .pat_i  (oam_rdata[23:16]),
    .hit_o  (hit),
    .addr_o (row_addr)
  );

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sel_d  = sel_q;
    line_d = line_q;
    tall_d = tall_q;
    done_d = 1'b0;
    wr_en  = 1'b0;
    case (st_q)
      SCAN_IDLE: begin
        if (start) begin
          st_d   = SCAN_RUN;
          cnt_d  = '0;
          sel_d  = '0;
          line_d = line_y;
          tall_d = tall;
        end
      end
      SCAN_RUN: begin
        if (hit && (sel_q < CNT_W'(MAX_SEL))) begin
          wr_en = 1'b1;
          sel_d = sel_q + 1'b1;
        end
        if (cnt_q == IDX_W'(LAST)) begin
          st_d   = SCAN_IDLE;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = SCAN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      st_q   <= SCAN_IDLE;
      cnt_q  <= '0;
      sel_q  <= '0;
      line_q <= '0;
      tall_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sel_q  <= sel_d;
      line_q <= line_d;
      tall_q <= tall_d;
      done_q <= done_d;
    end
  end

  logic [MAX_SEL-1:0][7:0]       x_all;
  logic [MAX_SEL-1:0][IDX_W-1:0] idx_all;

  spr_slots #(.MAX_SEL(MAX_SEL), .IDX_W(IDX_W), .SLOT_W(SLOT_W), .ADDR_W(16)) u_slots (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_slot (sel_q[SLOT_W-1:0]),
    .wr_idx  (cnt_q),
    .wr_x    (oam_rdata[15:8]),
    .wr_addr (row_addr),
    .rd_slot (rd_slot),
    .rd_idx  (rd_idx),
    .rd_x    (rd_x),
    .rd_addr (rd_addr),
    .x_all   (x_all),
    .idx_all (idx_all)
  );

  spr_prio #(.MAX_SEL(MAX_SEL), .IDX_W(IDX_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W),
             .XOFS(XOFS), .SPR_W(8)) u_prio (
    .pix_i     (pix_x),
    .cnt_i     (sel_q),
    .x_all     (x_all),
    .idx_all   (idx_all),
    .win_valid (win_valid),
    .win_slot  (win_slot),
    .win_idx   (win_idx)
  );

  assign oam_idx  = cnt_q;
  assign busy     = (st_q == SCAN_RUN);
  assign done     = done_q;
  assign slot_cnt = sel_q;

endmodule

// File: rtl/spr_line_sel_chk.sv
module spr_line_sel_chk #(
  parameter int N_ENT   = 40,
  parameter int MAX_SEL = 10,
  parameter int IDX_W   = 6,
  parameter int SLOT_W  = 4,
  parameter int CNT_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [IDX_W-1:0]  oam_idx,
  input logic [CNT_W-1:0]  slot_cnt,
  input logic              win_valid,
  input logic [SLOT_W-1:0] win_slot,
  input logic [IDX_W-1:0]  win_idx
);
  AST_SLOT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    slot_cnt <= CNT_W'(MAX_SEL)); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R1

  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && oam_idx != IDX_W'(N_ENT - 1)) |=> (busy && oam_idx == IDX_W'($past(oam_idx) + 1'b1))); // R1

  AST_SCAN_END: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && oam_idx == IDX_W'(N_ENT - 1)) |=> (done && !busy)); // R1

  AST_LIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(slot_cnt)); // R6

  AST_WIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> (win_slot == '0 && win_idx == '0)); // R9

  AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (CNT_W'(win_slot) < slot_cnt)); // R8

endmodule

bind spr_line_sel spr_line_sel_chk #(
  .N_ENT(N_ENT), .MAX_SEL(MAX_SEL), .IDX_W(IDX_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .oam_idx(oam_idx), .slot_cnt(slot_cnt), .win_valid(win_valid),
  .win_slot(win_slot), .win_idx(win_idx)
);

// File: tb/sim_spr_line_sel.sv
`timescale 1ns/1ps
module sim_spr_line_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  line_y = '0;
  logic        tall = 1'b0;
  logic [5:0]  oam_idx;
  logic [31:0] oam_rdata;
  logic        busy, done;
  logic [3:0]  slot_cnt;
  logic [3:0]  rd_slot = '0;
  logic [5:0]  rd_idx;
  logic [7:0]  rd_x;
  logic [15:0] rd_addr;
  logic [7:0]  pix_x = '0;
  logic        win_valid;
  logic [3:0]  win_slot;
  logic [5:0]  win_idx;

  // second instance with zero vertical offset for the hidden-entry rule
  logic        start1 = 1'b0;
  logic [5:0]  oam_idx1;
  logic [31:0] oam_rdata1;
  logic        busy1, done1;
  logic [3:0]  slot_cnt1;
  logic [3:0]  rd_slot1 = '0;
  logic [5:0]  rd_idx1;
  logic [7:0]  rd_x1;
  logic [15:0] rd_addr1;
  logic        wv1;
  logic [3:0]  ws1;
  logic [5:0]  wi1;

  logic [31:0] mem  [40];
  logic [31:0] mem1 [40];

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  always_comb oam_rdata  = (oam_idx  < 6'd40) ? mem[oam_idx]   : 32'h0;
  always_comb oam_rdata1 = (oam_idx1 < 6'd40) ? mem1[oam_idx1] : 32'h0;

  spr_line_sel u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .line_y(line_y), .tall(tall),
    .oam_idx(oam_idx), .oam_rdata(oam_rdata), .busy(busy), .done(done),
    .slot_cnt(slot_cnt), .rd_slot(rd_slot), .rd_idx(rd_idx), .rd_x(rd_x),
    .rd_addr(rd_addr), .pix_x(pix_x), .win_valid(win_valid),
    .win_slot(win_slot), .win_idx(win_idx)
  );

  spr_line_sel #(.YOFS(0)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start1), .line_y(8'd0), .tall(1'b0),
    .oam_idx(oam_idx1), .oam_rdata(oam_rdata1), .busy(busy1), .done(done1),
    .slot_cnt(slot_cnt1), .rd_slot(rd_slot1), .rd_idx(rd_idx1), .rd_x(rd_x1),
    .rd_addr(rd_addr1), .pix_x(8'd0), .win_valid(wv1),
    .win_slot(ws1), .win_idx(wi1)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------- scoreboard ----------
  logic [29:0] exp_q[$];
  int          exp_cnt;
  string       exp_tag;
  int          ex_n;
  int          ex_x [10];
  int          ex_i [10];

  function automatic logic [32:0] model_entry(input logic [31:0] w, input int line,
                                              input bit tl, input int yofs);
    int y, x, p, d, h, tile;
    logic [15:0] a;
    bit hit;
    y = w[7:0]; x = w[15:8]; p = w[23:16];
    d = line + yofs - y;
    h = tl ? 16 : 8;
    hit = (d >= 0) && (d < h) && !(x == 0 && y == 0);
    tile = tl ? (p & 8'hFE) : p;
    a = 16'(32'h8000 + tile * 16 + (d & (h - 1)) * 2);
    return {hit, 16'(x), a};
  endfunction

  // driver: builds expected list and runs one scan
  task automatic run_line(input int line, input bit tl, input string tag);
    logic [32:0] m;
    int k;
    exp_q.delete();
    ex_n = 0;
    for (int e = 0; e < 40; e++) begin
      m = model_entry(mem[e], line, tl, 16);
      if (m[32] && ex_n < 10) begin
        exp_q.push_back({6'(e), m[23:16], m[15:0]});
        ex_x[ex_n] = m[23:16];
        ex_i[ex_n] = e;
        ex_n++;
      end
    end
    exp_cnt = ex_n;
    exp_tag = tag;
    @(negedge clk);
    line_y = 8'(line); tall = tl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1 busy after start", busy, 1);
    check("R1 first entry", oam_idx, 0);
    k = 0;
    while (!done && k < 100) begin @(negedge clk); k++; end
    check("R1 cycles to done", k, 40);
    check("R1 busy fall", busy, 0);
    wait (exp_q.size() == 0);
    @(negedge clk);
    check("R1 done one cycle", done, 0);
  endtask

  // monitor: compares list readout against expected queue
  initial begin
    logic [29:0] it;
    forever begin
      @(posedge clk);
      if (done) begin
        @(negedge clk);
        check({exp_tag, " R3 slot_cnt"}, slot_cnt, exp_cnt);
        for (int s = 0; s < exp_cnt; s++) begin
          it = exp_q[0];
          rd_slot = 4'(s);
          #1;
          check({exp_tag, " R6 idx"}, rd_idx, it[29:24]);
          check({exp_tag, " R6 x"}, rd_x, it[23:16]);
          check({exp_tag, " R5 addr"}, rd_addr, it[15:0]);
          void'(exp_q.pop_front());
        end
        exp_q.delete();
      end
    end
  end

  task automatic check_pix(input int p, input string tag);
    int bs, bx, rel;
    bit bv;
    bv = 0; bs = 0; bx = 0;
    for (int s = 0; s < ex_n; s++) begin
      rel = p + 8 - ex_x[s];
      if (rel >= 0 && rel < 8 && (!bv || ex_x[s] < bx)) begin
        bv = 1; bs = s; bx = ex_x[s];
      end
    end
    @(negedge clk);
    pix_x = 8'(p);
    #1;
    check({tag, " valid"}, win_valid, bv);
    check({tag, " slot"}, win_slot, bv ? bs : 0);
    check({tag, " idx"}, win_idx, bv ? ex_i[bs] : 0);
  endtask

  function automatic logic [31:0] ent(input int y, input int x, input int p);
    return {8'h00, 8'(p), 8'(x), 8'(y)};
  endfunction

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int e = 0; e < 40; e++) begin mem[e] = 32'h0; mem1[e] = 32'h0; end
    repeat (3) @(negedge clk);
    check("R10 busy", busy, 0);
    check("R10 done", done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 slot_cnt", slot_cnt, 0);
    check("R10 win_valid", win_valid, 0);

    // scenario A: line 20, short sprites
    mem[3]  = ent(36, 30, 8'h11);  // row 0
    mem[5]  = ent(30, 30, 8'h22);  // row 6, same X as entry 3
    mem[7]  = ent(29, 50, 8'h33);  // row 7, last short row
    mem[8]  = ent(28, 70, 8'h23);  // d = 8: miss short, hit tall
    mem[9]  = ent(37, 90, 8'h44);  // d = -1: miss
    mem[10] = ent(36, 27, 8'h55);  // smaller X, later entry
    run_line(20, 0, "A R2");
    check("R2 A count", slot_cnt, 4);
    check_pix(24, "R8 smaller X wins");
    check_pix(28, "R8 equal X lower index");
    check_pix(22, "R7 left edge");
    check_pix(21, "R7 before left edge");
    check_pix(29, "R7 right edge");
    check_pix(45, "R7 single cover");
    check_pix(10, "R9 no cover");
    check_pix(30, "R9 past right");

    // scenario B: same table, tall sprites
    run_line(20, 1, "B R5");
    check("R5 B count", slot_cnt, 5);
    check_pix(64, "R8 tall cover");
    check_pix(200, "R9 tall none");

    // scenario C: overflow with interleaved misses
    for (int e = 0; e < 40; e++) mem[e] = ent(200, 100, e);
    for (int k = 0; k < 12; k++) mem[k * 3 + 1] = ent(60, 40 + k * 4, 2 * k + 1);
    mem[31] = ent(60, 12, 8'h77);  // 11th match, low X, must be dropped
    run_line(50, 0, "C R3");
    check("R3 C count", slot_cnt, 10);
    check_pix(6, "R3 dropped sprite absent");
    check_pix(36, "R8 first kept");
    check_pix(8, "R9 gap");

    // hidden entries on the zero-offset instance
    mem1[0] = ent(0, 0, 8'h01);
    mem1[1] = ent(0, 5, 8'h02);
    mem1[2] = ent(0, 0, 8'h03);
    @(negedge clk); start1 = 1'b1;
    @(negedge clk); start1 = 1'b0;
    while (!done1) @(negedge clk);
    @(negedge clk);
    check("R4 hidden count", slot_cnt1, 1);
    rd_slot1 = 4'd0;
    #1;
    check("R4 visible index", rd_idx1, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule